// File: doc/BRIEF.md
# Sleep Mode and Wake-up Sequencer

This block decides when a small processor core may stop and how it comes back. Software writes a four-bit control word that holds an arm bit and a three-bit mode code. When the core then pulses its sleep strobe with the arm bit set, the sequencer halts the core and drops the clock enables that the chosen low-power mode does not need. The enables cover the CPU clock, the I/O clock, the converter clock, the asynchronous timer clock and the main oscillator.

While the core sleeps, the block watches the interrupt request lines through their mask and also watches a reset request input. An unmasked interrupt starts the wake sequence. First comes a start-up wait that depends on the mode. Then comes a fixed four-cycle halt with every clock running. After that the core is released and a one-cycle flag tells it to take the interrupt and carry on from the instruction after its sleep. A reset request beats everything. It returns the block to the running state on the next edge, clears the control word, and raises a one-cycle flag that sends the core to its reset vector. Storage contents are never touched by the sequencer.

Top module: `slp_wake_ctrl`

## Requirements
- R1: A write with `cfg_we` high loads `cfg_wdata` into the control word on the next edge (bit 0 is the arm bit, bits 3:1 the mode code), and the word is visible on `ctrl_q`. If the core is running, `sleep_strb` is high, the arm bit is 1 and `rst_req` is low, then `core_halt` is 1 after the next edge.
- R2: A `sleep_strb` pulse while the arm bit is 0 has no effect. `core_halt` stays 0 and every clock enable stays 1.
- R3: While asleep, the clock enables {cpu, io, adc, tmr, osc} follow the mode latched at entry. Mode 000 gives 01111, 001 gives 00111, 010 gives 00000, 011 gives 00010 and 110 gives 00001. `cpu_clk_en` is never 0 unless `core_halt` is 1.
- R4: The reserved mode codes 100, 101 and 111 behave exactly like code 000.
- R5: While asleep, an interrupt with its request bit and its mask bit both 1 starts the wake sequence. A request whose mask bit is 0 leaves the core asleep.
- R6: The start-up wait D is `startup_cycles` (sampled at wake) for codes 010 and 011, the parameter `STBY_DELAY` (default 6) for code 110, and 0 for every other code. `core_halt` falls on the edge that comes D+4 edges after the edge that sampled the interrupt.
- R7: The last four cycles before release have `core_halt` at 1 with all clock enables at 1.
- R8: After an interrupt wake, `resume_irq` is 1 for exactly the first running cycle and is 0 at all other times.
- R9: `rst_req` in any state gives, after the next edge, `core_halt` at 0, every clock enable at 1, the control word cleared and `resume_rst` at 1 for one cycle.
- R10: When `rst_req` and an unmasked interrupt arrive in the same cycle, the reset path wins: `resume_rst` goes to 1 and `resume_irq` stays 0.
- R11: During the start-up wait, `osc_en` is 1 and `cpu_clk_en` is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word write data: bit 0 arm, bits 3:1 mode |
| ctrl_q | output | 4 | Current control word |
| sleep_strb | input | 1 | Sleep instruction strobe from the core |
| irq_req | input | IRQ_N | Interrupt request lines |
| irq_en | input | IRQ_N | Interrupt mask, 1 = enabled |
| rst_req | input | 1 | Reset event, wakes to the reset vector |
| startup_cycles | input | CNT_W | Start-up wait for the two deepest oscillator-off modes |
| core_halt | output | 1 | Core must not execute |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| tmr_clk_en | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| resume_irq | output | 1 | One-cycle flag: resume through the interrupt path |
| resume_rst | output | 1 | One-cycle flag: resume at the reset vector |

## Verification
Every result of this sequencer is registered once. A control write, a sleep strobe or a reset request shows up one edge later, so the bench drives on a falling edge and reads on the next falling edge. Wake timing is the long path. The bench computes D from the mode and the sampled start-up count, then counts falling edges from the one after the sampling edge, and expects `core_halt` low and `resume_irq` high on count D+5. It checks the start-up wait on count 1 and the first halt cycle on count D+1. The flag pulses are checked again one falling edge later to confirm they drop.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_SLEEP   = 2'd1,
      ST_STARTUP = 2'd2,
      ST_HALT4   = 2'd3
   } slp_state_e;

   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] MODE_LITE    = 3'b000;
   localparam logic [MODE_W-1:0] MODE_QUIET   = 3'b001;
   localparam logic [MODE_W-1:0] MODE_DEEP    = 3'b010;
   localparam logic [MODE_W-1:0] MODE_KEEPTMR = 3'b011;
   localparam logic [MODE_W-1:0] MODE_STANDBY = 3'b110;

   typedef struct packed {
      logic cpu;
      logic io;
      logic adc;
      logic tmr;
      logic osc;
   } clk_gate_t;

   localparam clk_gate_t GATE_ALL_ON = 5'b11111;

   // clock enables kept alive by each low-power mode
   function automatic clk_gate_t mode_gate(input logic [MODE_W-1:0] m);
      clk_gate_t g;
      case (m)
         MODE_QUIET:   g = 5'b00111;
         MODE_DEEP:    g = 5'b00000;
         MODE_KEEPTMR: g = 5'b00010;
         MODE_STANDBY: g = 5'b00001;
         default:      g = 5'b01111;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg #(
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [MODE_W:0]   wdata,
   output logic              arm,
   output logic [MODE_W-1:0] mode
);

   logic [MODE_W:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (clr) begin
         word_q <= '0;
      end else if (we) begin
         word_q <= wdata;
      end
   end

   assign arm  = word_q[0];
   assign mode = word_q[MODE_W:1];

endmodule

// File: rtl/slp_gate_dec.sv
module slp_gate_dec
   import slp_pkg::*;
(
   input  slp_state_e        state,
   input  logic [MODE_W-1:0] mode,
   output clk_gate_t         gate
);

   always_comb begin
      case (state)
         ST_SLEEP: gate = mode_gate(mode);
         ST_STARTUP: begin
            gate     = mode_gate(mode);
            gate.osc = 1'b1;
         end
         default: gate = GATE_ALL_ON;
      endcase
   end

endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
   import slp_pkg::*;
#(
   parameter int IRQ_N      = 8,
   parameter int CNT_W      = 8,
   parameter int STBY_DELAY = 6,
   parameter bit SYNC_IRQ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req,
   input  logic              go_sleep,
   input  logic [MODE_W-1:0] mode_in,
   input  logic [IRQ_N-1:0]  irq_req,
   input  logic [IRQ_N-1:0]  irq_en,
   input  logic [CNT_W-1:0]  startup_cycles,
   output slp_state_e        state,
   output logic [MODE_W-1:0] mode_q,
   output logic              resume_irq,
   output logic              resume_rst
);

   localparam int HALT_N = 4;
   localparam logic [CNT_W-1:0] HALT_LAST = CNT_W'(HALT_N - 1);
   localparam logic [CNT_W-1:0] STBY_CNT  = CNT_W'(STBY_DELAY);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   logic             irq_hit;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wake_delay;

   generate
      if (SYNC_IRQ) begin : g_irq_sync
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= |(irq_req & irq_en);
         end
         assign irq_hit = hit_q;
      end else begin : g_irq_direct
         assign irq_hit = |(irq_req & irq_en);
      end
   endgenerate

   always_comb begin
      case (mode_q)
         MODE_DEEP, MODE_KEEPTMR: wake_delay = startup_cycles;
         MODE_STANDBY:            wake_delay = STBY_CNT;
         default:                 wake_delay = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_RUN;
         cnt_q      <= '0;
         mode_q     <= '0;
         resume_irq <= 1'b0;
         resume_rst <= 1'b0;
      end else begin
         resume_irq <= 1'b0;
         resume_rst <= 1'b0;
         if (rst_req) begin
            state      <= ST_RUN;
            cnt_q      <= '0;
            resume_rst <= 1'b1;
         end else begin
            case (state)
               ST_RUN: begin
                  if (go_sleep) begin
                     state  <= ST_SLEEP;
                     mode_q <= mode_in;
                  end
               end
               ST_SLEEP: begin
                  if (irq_hit) begin
                     if (wake_delay == '0) begin
                        state <= ST_HALT4;
                        cnt_q <= HALT_LAST;
                     end else begin
                        state <= ST_STARTUP;
                        cnt_q <= wake_delay;
                     end
                  end
               end
               ST_STARTUP: begin
                  if (cnt_q == CNT_ONE) begin
                     state <= ST_HALT4;
                     cnt_q <= HALT_LAST;
                  end else begin
                     cnt_q <= cnt_q - CNT_ONE;
                  end
               end
               default: begin
                  if (cnt_q == '0) begin
                     state      <= ST_RUN;
                     resume_irq <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q - CNT_ONE;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
   import slp_pkg::*;
#(
   parameter int IRQ_N      = 8,
   parameter int CNT_W      = 8,
   parameter int STBY_DELAY = 6,
   parameter bit SYNC_IRQ   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [3:0]       cfg_wdata,
   output logic [3:0]       ctrl_q,
   input  logic             sleep_strb,
   input  logic [IRQ_N-1:0] irq_req,
   input  logic [IRQ_N-1:0] irq_en,
   input  logic             rst_req,
   input  logic [CNT_W-1:0] startup_cycles,
   output logic             core_halt,
   output logic             cpu_clk_en,
   output logic             io_clk_en,
   output logic             adc_clk_en,
   output logic             tmr_clk_en,
   output logic             osc_en,
   output logic             resume_irq,
   output logic             resume_rst
);

   generate
      if (IRQ_N < 1) begin : g_bad_irq
         $error("IRQ_N must be at least 1");
      end
      if (CNT_W < 3) begin : g_bad_cnt
         $error("CNT_W must be at least 3");
      end
      if (STBY_DELAY < 1 || STBY_DELAY >= (1 << CNT_W)) begin : g_bad_stby
         $error("STBY_DELAY must be nonzero and fit in CNT_W bits");
      end
   endgenerate

   logic              arm;
   logic [MODE_W-1:0] cfg_mode;
   logic [MODE_W-1:0] mode_q;
   slp_state_e        state;
   clk_gate_t         gate;

   slp_ctrl_reg #(.MODE_W(MODE_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rst_req),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .arm   (arm),
      .mode  (cfg_mode)
   );

   slp_wake_seq #(
      .IRQ_N      (IRQ_N),
      .CNT_W      (CNT_W),
      .STBY_DELAY (STBY_DELAY),
      .SYNC_IRQ   (SYNC_IRQ)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .rst_req        (rst_req),
      .go_sleep       (sleep_strb & arm),
      .mode_in        (cfg_mode),
      .irq_req        (irq_req),
      .irq_en         (irq_en),
      .startup_cycles (startup_cycles),
      .state          (state),
      .mode_q         (mode_q),
      .resume_irq     (resume_irq),
      .resume_rst     (resume_rst)
   );

   slp_gate_dec u_dec (
      .state (state),
      .mode  (mode_q),
      .gate  (gate)
   );

   assign ctrl_q     = {cfg_mode, arm};
   assign core_halt  = (state != ST_RUN);
   assign cpu_clk_en = gate.cpu;
   assign io_clk_en  = gate.io;
   assign adc_clk_en = gate.adc;
   assign tmr_clk_en = gate.tmr;
   assign osc_en     = gate.osc;

endmodule

// File: rtl/slp_wake_chk.sv
module slp_wake_chk #(
   parameter int IRQ_N = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep_strb,
   input logic             ctrl_en,
   input logic [IRQ_N-1:0] irq_req,
   input logic [IRQ_N-1:0] irq_en,
   input logic             rst_req,
   input logic             core_halt,
   input logic             cpu_clk_en,
   input logic             resume_irq,
   input logic             resume_rst
);

   assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_halt && sleep_strb && ctrl_en && !rst_req) |=> core_halt);

   assert_unarmed_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_halt && sleep_strb && !ctrl_en && !rst_req) |=> !core_halt);

   assert_cpu_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clk_en |-> core_halt);

   assert_halt_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resume_irq |-> ($past(core_halt, 1) && $past(cpu_clk_en, 1) &&
                      $past(core_halt, 4) && $past(cpu_clk_en, 4)));

   assert_resume_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resume_irq |=> !resume_irq);

   assert_resume_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resume_irq |-> !core_halt);

   assert_reset_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (resume_rst && !core_halt));

   assert_reset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && |(irq_req & irq_en)) |=> (resume_rst && !resume_irq));

   assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(resume_irq && resume_rst));

endmodule

bind slp_wake_ctrl slp_wake_chk #(.IRQ_N(IRQ_N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep_strb (sleep_strb),
   .ctrl_en    (ctrl_q[0]),
   .irq_req    (irq_req),
   .irq_en     (irq_en),
   .rst_req    (rst_req),
   .core_halt  (core_halt),
   .cpu_clk_en (cpu_clk_en),
   .resume_irq (resume_irq),
   .resume_rst (resume_rst)
);

// File: tb/sim_slp_wake_ctrl.sv
`timescale 1ns/1ps
module sim_slp_wake_ctrl;

   localparam int IRQ_N = 8;
   localparam int CNT_W = 8;
   localparam int STBY  = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [3:0]       cfg_wdata = '0;
   logic [3:0]       ctrl_q;
   logic             sleep_strb = 1'b0;
   logic [IRQ_N-1:0] irq_req = '0;
   logic [IRQ_N-1:0] irq_en = '0;
   logic             rst_req = 1'b0;
   logic [CNT_W-1:0] startup_cycles = '0;
   logic             core_halt, cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, osc_en;
   logic             resume_irq, resume_rst;

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   slp_wake_ctrl #(.IRQ_N(IRQ_N), .CNT_W(CNT_W), .STBY_DELAY(STBY)) u0 (.*);

   function automatic logic [4:0] exp_gate(input logic [2:0] m);
      case (m)
         3'b001:  return 5'b00111;
         3'b010:  return 5'b00000;
         3'b011:  return 5'b00010;
         3'b110:  return 5'b00001;
         default: return 5'b01111;
      endcase
   endfunction

   function automatic int exp_delay(input logic [2:0] m, input int sc);
      if (m == 3'b010 || m == 3'b011) return sc;
      if (m == 3'b110) return STBY;
      return 0;
   endfunction

   function automatic logic [4:0] gates();
      return {cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, osc_en};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_ctrl(input logic [2:0] m, input logic arm);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = {m, arm};
      @(negedge clk);
      cfg_we = 1'b0;
      check("R1 ctrl readback", ctrl_q, {m, arm});
   endtask

   // kind: 0 irq wake, 1 reset wake, 2 reset and irq together
   task automatic sleep_cycle(input logic [2:0] m, input int sc, input int kind, input int bitn);
      int d;
      int k;
      write_ctrl(m, 1'b1);
      startup_cycles = CNT_W'(sc);
      sleep_strb = 1'b1;
      @(negedge clk);
      sleep_strb = 1'b0;
      check("R1 halted after strobe", core_halt, 1'b1);
      if (m == 3'b100 || m == 3'b101 || m == 3'b111)
         check("R4 reserved gating", gates(), exp_gate(m));
      else
         check("R3 mode gating", gates(), exp_gate(m));
      irq_req[bitn] = 1'b1; irq_en = '0;
      repeat (2) @(negedge clk);
      irq_req = '0;
      check("R5 masked irq ignored", core_halt, 1'b1);
      irq_en = '1;
      if (kind != 1) irq_req[bitn] = 1'b1;
      if (kind != 0) rst_req = 1'b1;
      @(negedge clk);
      irq_req = '0; rst_req = 1'b0;
      if (kind != 0) begin
         check("R9 reset wake running", core_halt, 1'b0);
         check("R9 resume_rst", resume_rst, 1'b1);
         check("R9 ctrl cleared", ctrl_q, 4'h0);
         check("R9 clocks on", gates(), 5'b11111);
         check("R10 no irq resume", resume_irq, 1'b0);
         @(negedge clk);
         check("R9 resume_rst one cycle", resume_rst, 1'b0);
      end else begin
         d = exp_delay(m, sc);
         k = 1;
         if (d > 0) check("R11 startup osc/cpu", {osc_en, cpu_clk_en}, 2'b10);
         while (core_halt && k < 400) begin
            if (k == d + 1) check("R7 halt with clocks", {core_halt, gates()}, 6'b111111);
            @(negedge clk);
            k++;
         end
         check("R6 release latency", k, d + 5);
         check("R8 resume_irq", resume_irq, 1'b1);
         @(negedge clk);
         check("R8 resume_irq one cycle", resume_irq, 1'b0);
      end
      irq_en = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: got hang expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      int r;
      r = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset state halt", core_halt, 1'b0);
      check("R9 reset state clocks", gates(), 5'b11111);
      check("R1 reset ctrl", ctrl_q, 4'h0);
      check("R8 reset flags", {resume_irq, resume_rst}, 2'b00);

      // R2: unarmed strobe
      write_ctrl(3'b010, 1'b0);
      sleep_strb = 1'b1;
      @(negedge clk);
      sleep_strb = 1'b0;
      check("R2 unarmed no halt", core_halt, 1'b0);
      check("R2 unarmed clocks", gates(), 5'b11111);
      @(negedge clk);
      check("R2 still running", core_halt, 1'b0);

      // directed modes
      sleep_cycle(3'b000, 9, 0, 0);
      sleep_cycle(3'b001, 9, 0, 3);
      sleep_cycle(3'b010, 12, 0, 7);
      sleep_cycle(3'b010, 0, 0, 1);
      sleep_cycle(3'b011, 1, 0, 2);
      sleep_cycle(3'b110, 30, 0, 4);
      sleep_cycle(3'b100, 5, 0, 5);
      sleep_cycle(3'b101, 5, 0, 6);
      sleep_cycle(3'b111, 5, 0, 0);
      sleep_cycle(3'b010, 8, 1, 2);
      sleep_cycle(3'b011, 8, 2, 3);

      // reset during start-up wait
      write_ctrl(3'b010, 1'b1);
      startup_cycles = 8'd10;
      sleep_strb = 1'b1;
      @(negedge clk);
      sleep_strb = 1'b0;
      irq_en = '1; irq_req = 8'h01;
      @(negedge clk);
      irq_req = '0;
      repeat (3) @(negedge clk);
      check("R11 in startup", {core_halt, osc_en, cpu_clk_en}, 3'b110);
      rst_req = 1'b1;
      @(negedge clk);
      rst_req = 1'b0;
      check("R9 reset in startup", {core_halt, resume_rst, resume_irq}, 3'b010);
      irq_en = '0;
      repeat (20) @(negedge clk);
      check("R8 no late resume", resume_irq, 1'b0);

      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [2:0] m;
         int sc, kind, b;
         m    = 3'($urandom % 8);
         sc   = int'($urandom % 24);
         kind = int'($urandom % 4);
         if (kind == 3) kind = 0;
         b    = int'($urandom % IRQ_N);
         sleep_cycle(m, sc, kind, b);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule